// File: doc/BRIEF.md
# Two-Bank Interrupt Request Controller

This block gathers sixteen peripheral interrupt sources into two banks of eight (bank A holds sources 0 to 7, bank B holds sources 8 to 15). It drives one normal interrupt line and one fast interrupt line to the processor. Software reaches it through a byte-wide register port with a 3-bit address. Each bank has three views: the raw state of its sources, the same state gated by the bank's mask, and the mask itself. A third group of eight fast sources has its own state view and mask, and these drive the fast interrupt line.

Bank A mixes two kinds of source. The bits selected by the `EDGE_BITS_A` parameter (default bits 2 and 3) catch a rising edge and hold it until software clears it. Every other bit, in both banks, follows its input pin. To clear held edges, software writes a byte to the bank A request address. Each bit set to one in that byte clears the matching held edge. Reads have no side effects. The read data is combinational from the address, and the interrupt outputs are combinational from the sources and the held state.

Top module: `irqc_top`

Register addresses: 0 bank A state (read only), 1 bank A request (read: state AND mask; write: clear held edges), 2 bank A mask, 3 bank B state (read only), 4 bank B request (read only), 5 bank B mask, 6 fast source state (read only), 7 fast mask.

## Requirements
- R1: A read at address 0 or 3 returns the bank's current source state, whatever the mask holds. For level bits, the state is the input pin in that same cycle.
- R2: A read at address 1 or 4 returns that bank's state AND that bank's mask.
- R3: An edge bit of bank A (bits 2 and 3 by default) is set by the clock edge after its input goes from 0 to 1. It stays set after the input falls.
- R4: A write at address 1 clears each held edge bit whose data bit is one. It leaves the edge bits whose data bit is zero, and the level bits, unchanged. When a rising edge and a clear for the same bit meet at the same clock edge, the bit stays set.
- R5: `irq_out` is high exactly when the bank A request byte or the bank B request byte is nonzero.
- R6: `fiq_out` is high exactly when the fast sources AND the fast mask are nonzero. A read at address 6 returns the fast source state.
- R7: A read at address 2, 5 or 7 returns the last byte written to that address. The new value shows from the clock edge that takes the write.
- R8: Writes at addresses 0, 3, 4 and 6 change no mask and no held edge bit.
- R9: Reset (synchronous, active high) sets all three masks to zero and clears every held edge bit.
- R10: With all masks at zero, both outputs stay low while held edge bits remain visible in the bank A state. Restoring a mask makes the pending request drive `irq_out` again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe for the current address |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte for the current address |
| src_a | input | 8 | Bank A interrupt sources (sources 0 to 7) |
| src_b | input | 8 | Bank B interrupt sources (sources 8 to 15) |
| src_f | input | 8 | Fast interrupt sources |
| irq_out | output | 1 | Normal interrupt request to the processor |
| fiq_out | output | 1 | Fast interrupt request to the processor |

## Verification
The masking path is tried with sparse, dense and disjoint combinations of source and mask bytes. This shows whether the state view really ignores the mask and whether the request and output paths really use it. Single-cycle pulses on the edge bits, followed by partial clears, separate a held edge from a followed level. They also show whether a clear byte hits only the intended bits. One pulse lands on the same edge as its own clear, which exposes the wrong set/clear priority. Writes to every read-only address, the all-masks-zero case and a long run of mixed random traffic complete the coverage.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_STATE_A = 3'd0,
        REG_REQ_A   = 3'd1,
        REG_MASK_A  = 3'd2,
        REG_STATE_B = 3'd3,
        REG_REQ_B   = 3'd4,
        REG_MASK_B  = 3'd5,
        REG_STATE_F = 3'd6,
        REG_MASK_F  = 3'd7
    } reg_sel_e;

    // Decoded write intent for one cycle
    typedef struct packed {
        logic  ld_mask_a;
        logic  ld_mask_b;
        logic  ld_mask_f;
        logic  clr_a;
        byte_t data;
    } wr_cmd_t;

    // State and mask view of one source group
    typedef struct packed {
        byte_t state;
        byte_t mask;
        byte_t req;
    } group_view_t;

    function automatic logic any_set(input byte_t v);
        return |v;
    endfunction

endpackage

// File: rtl/irqc_edge_cell.sv
module irqc_edge_cell (
    input  logic clk,
    input  logic rst,
    input  logic src,
    input  logic clr,
    output logic held
);
    logic prev_q;
    logic held_q;

    // A new rising edge takes priority over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            held_q <= 1'b0;
        end else begin
            prev_q <= src;
            held_q <= (held_q & ~clr) | (src & ~prev_q);
        end
    end

    assign held = held_q;
endmodule

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg
    import irqc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ld,
    input  byte_t wdata,
    input  byte_t state,
    output group_view_t view
);
    byte_t mask_q;

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (ld)
            mask_q <= wdata;
    end

    always_comb begin
        view.state = state;
        view.mask  = mask_q;
        view.req   = state & mask_q;
    end
endmodule

// File: rtl/irqc_regif.sv
module irqc_regif
    import irqc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  byte_t             wdata,
    input  group_view_t       grp_a,
    input  group_view_t       grp_b,
    input  group_view_t       grp_f,
    output wr_cmd_t           cmd,
    output byte_t             rdata
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    always_comb begin
        cmd           = '0;
        cmd.data      = wdata;
        cmd.ld_mask_a = wr_en && (sel == REG_MASK_A);
        cmd.ld_mask_b = wr_en && (sel == REG_MASK_B);
        cmd.ld_mask_f = wr_en && (sel == REG_MASK_F);
        cmd.clr_a     = wr_en && (sel == REG_REQ_A);
    end

    // The fast group's request byte only feeds the output, never the read path
    byte_t unused_req_f;
    assign unused_req_f = grp_f.req;

    always_comb begin
        unique case (sel)
            REG_STATE_A: rdata = grp_a.state;
            REG_REQ_A:   rdata = grp_a.req;
            REG_MASK_A:  rdata = grp_a.mask;
            REG_STATE_B: rdata = grp_b.state;
            REG_REQ_B:   rdata = grp_b.req;
            REG_MASK_B:  rdata = grp_b.mask;
            REG_STATE_F: rdata = grp_f.state;
            REG_MASK_F:  rdata = grp_f.mask | (unused_req_f & 8'h00);
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter logic [7:0] EDGE_BITS_A = 8'h0C
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  addr,
    input  logic        wr_en,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    input  logic [7:0]  src_a,
    input  logic [7:0]  src_b,
    input  logic [7:0]  src_f,
    output logic        irq_out,
    output logic        fiq_out
);
    wr_cmd_t     cmd;
    group_view_t grp_a, grp_b, grp_f;
    byte_t       stat_a;
    byte_t       mask_a, mask_b, mask_f;

    // Bank A state: held edge bits or followed level bits, picked per bit
    for (genvar i = 0; i < BYTE_W; i++) begin : g_bank_a
        if (EDGE_BITS_A[i]) begin : g_edge
            irqc_edge_cell u_cell (
                .clk  (clk),
                .rst  (rst),
                .src  (src_a[i]),
                .clr  (cmd.clr_a & cmd.data[i]),
                .held (stat_a[i])
            );
        end else begin : g_level
            assign stat_a[i] = src_a[i];
        end
    end

    irqc_mask_reg u_grp_a (
        .clk(clk), .rst(rst), .ld(cmd.ld_mask_a), .wdata(cmd.data),
        .state(stat_a), .view(grp_a)
    );

    irqc_mask_reg u_grp_b (
        .clk(clk), .rst(rst), .ld(cmd.ld_mask_b), .wdata(cmd.data),
        .state(src_b), .view(grp_b)
    );

    irqc_mask_reg u_grp_f (
        .clk(clk), .rst(rst), .ld(cmd.ld_mask_f), .wdata(cmd.data),
        .state(src_f), .view(grp_f)
    );

    irqc_regif u_regif (
        .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .grp_a(grp_a), .grp_b(grp_b), .grp_f(grp_f),
        .cmd(cmd), .rdata(rdata)
    );

    assign mask_a  = grp_a.mask;
    assign mask_b  = grp_b.mask;
    assign mask_f  = grp_f.mask;
    assign irq_out = any_set(grp_a.req) | any_set(grp_b.req);
    assign fiq_out = any_set(grp_f.req);
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker (
    input logic       clk,
    input logic       rst,
    input logic [2:0] addr,
    input logic       wr_en,
    input logic [7:0] wdata,
    input logic [7:0] src_a,
    input logic [7:0] stat_a,
    input logic [7:0] mask_a,
    input logic [7:0] mask_b,
    input logic [7:0] mask_f,
    input logic       irq_out,
    input logic       fiq_out
);
    p_mask_readback_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 3'd2) |=> (mask_a == $past(wdata)));

    p_ro_write_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == 3'd0 || addr == 3'd3 || addr == 3'd4 || addr == 3'd6))
        |=> ($stable(mask_a) && $stable(mask_b) && $stable(mask_f)));

    p_edge_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (stat_a[2] && !(wr_en && addr == 3'd1 && wdata[2])) |=> stat_a[2]);

    p_edge_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 3'd1 && wdata[3] && !src_a[3]) |=> !stat_a[3]);

    p_reset_state_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_a == 8'h00 && mask_b == 8'h00 && mask_f == 8'h00));

    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (mask_a == 8'h00 && mask_b == 8'h00) |-> !irq_out);

    p_fiq_needs_mask_r6: assert property (@(posedge clk) disable iff (rst)
        fiq_out |-> (mask_f != 8'h00));
endmodule

bind irqc_top irqc_checker u_irqc_checker (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .src_a(src_a), .stat_a(stat_a), .mask_a(mask_a), .mask_b(mask_b),
    .mask_f(mask_f), .irq_out(irq_out), .fiq_out(fiq_out)
);

// File: tb/test_irqc_top.sv
module test_irqc_top;
    localparam logic [7:0] EDGE = 8'h0C;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] src_a = '0, src_b = '0, src_f = '0;
    logic       irq_out, fiq_out;

    int checks = 0;
    int errors = 0;
    string cur_req = "R9";

    // reference model state
    logic [7:0] m_ma = '0, m_mb = '0, m_mf = '0, m_held = '0, m_prev = '0;

    always #4 clk = ~clk;

    irqc_top i_irqc_top (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .src_a(src_a), .src_b(src_b), .src_f(src_f),
        .irq_out(irq_out), .fiq_out(fiq_out)
    );

    function automatic logic [7:0] m_state_a();
        return (m_held & EDGE) | (src_a & ~EDGE);
    endfunction

    function automatic logic [7:0] m_rdata(input logic [2:0] a);
        case (a)
            3'd0: return m_state_a();
            3'd1: return m_state_a() & m_ma;
            3'd2: return m_ma;
            3'd3: return src_b;
            3'd4: return src_b & m_mb;
            3'd5: return m_mb;
            3'd6: return src_f;
            default: return m_mf;
        endcase
    endfunction

    task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h (t=%0t)", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic [2:0] a, input logic w, input logic [7:0] d);
        logic [7:0] clr;
        addr = a; wr_en = w; wdata = d;
        #2;
        check("rdata", rdata, m_rdata(a));
        check("irq_out R5", {7'd0, irq_out},
              {7'd0, (|(m_state_a() & m_ma)) | (|(src_b & m_mb))});
        check("fiq_out R6", {7'd0, fiq_out}, {7'd0, |(src_f & m_mf)});
        @(posedge clk);
        if (rst) begin
            m_ma = '0; m_mb = '0; m_mf = '0; m_held = '0; m_prev = '0;
        end else begin
            clr = (w && a == 3'd1) ? d : 8'h00;
            m_held = ((m_held & ~clr) | (src_a & ~m_prev)) & EDGE;
            m_prev = src_a;
            if (w && a == 3'd2) m_ma = d;
            if (w && a == 3'd5) m_mb = d;
            if (w && a == 3'd7) m_mf = d;
        end
        @(negedge clk);
    endtask

    task automatic sweep();
        for (int k = 0; k < 8; k++) cyc(3'(k), 1'b0, 8'h00);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(posedge clk);
        @(negedge clk);
        // R9: reset state
        cur_req = "R9";
        cyc(3'd0, 1'b0, 8'h00);
        cyc(3'd2, 1'b0, 8'h00);
        rst = 1'b0;
        sweep();

        // R7: mask readback
        cur_req = "R7";
        cyc(3'd2, 1'b1, 8'hA5);
        cyc(3'd5, 1'b1, 8'h3C);
        cyc(3'd7, 1'b1, 8'h81);
        cyc(3'd2, 1'b0, 8'h00);
        cyc(3'd5, 1'b0, 8'h00);
        cyc(3'd7, 1'b0, 8'h00);

        // R1 R2 R5: level patterns
        cur_req = "R1";
        src_a = 8'h51; src_b = 8'h0F; sweep();
        cur_req = "R2";
        src_a = 8'hF3; src_b = 8'hC0; sweep();
        cur_req = "R5";
        src_a = 8'h00; src_b = 8'h10; sweep();
        src_b = 8'h00; sweep();

        // R3: single-cycle pulse on edge bit 2 is held
        cur_req = "R3";
        src_a = 8'h04; cyc(3'd0, 1'b0, 8'h00);
        src_a = 8'h00; cyc(3'd0, 1'b0, 8'h00);
        cyc(3'd0, 1'b0, 8'h00);
        cyc(3'd1, 1'b0, 8'h00);
        src_a = 8'h08; cyc(3'd0, 1'b0, 8'h00);
        src_a = 8'h00; sweep();

        // R4: partial clear, level bits unaffected, set beats clear
        cur_req = "R4";
        src_a = 8'h01;
        cyc(3'd1, 1'b1, 8'h09);
        cyc(3'd0, 1'b0, 8'h00);
        cyc(3'd1, 1'b1, 8'h04);
        cyc(3'd0, 1'b0, 8'h00);
        src_a = 8'h09; cyc(3'd1, 1'b1, 8'h08);
        cyc(3'd0, 1'b0, 8'h00);
        src_a = 8'h00; cyc(3'd1, 1'b1, 8'h0C);
        cyc(3'd0, 1'b0, 8'h00);

        // R6: fast path
        cur_req = "R6";
        src_f = 8'h80; cyc(3'd6, 1'b0, 8'h00);
        src_f = 8'h7E; cyc(3'd6, 1'b0, 8'h00);
        cyc(3'd7, 1'b1, 8'h02); cyc(3'd6, 1'b0, 8'h00);
        src_f = 8'h00; cyc(3'd6, 1'b0, 8'h00);

        // R8: writes to read-only addresses
        cur_req = "R8";
        src_a = 8'h04; cyc(3'd0, 1'b0, 8'h00);
        src_a = 8'h00;
        cyc(3'd0, 1'b1, 8'hFF); cyc(3'd3, 1'b1, 8'hFF);
        cyc(3'd4, 1'b1, 8'h00); cyc(3'd6, 1'b1, 8'hFF);
        sweep();

        // R10: all masks zero, pending edge stays visible
        cur_req = "R10";
        cyc(3'd2, 1'b1, 8'h00); cyc(3'd5, 1'b1, 8'h00); cyc(3'd7, 1'b1, 8'h00);
        src_b = 8'hFF; src_f = 8'hFF;
        sweep();
        cyc(3'd2, 1'b1, 8'h04);
        cyc(3'd1, 1'b0, 8'h00);
        src_b = 8'h00; src_f = 8'h00;
        cyc(3'd1, 1'b1, 8'h04);
        cyc(3'd1, 1'b0, 8'h00);

        // mixed random traffic across R1 to R8
        cur_req = "R2";
        for (int n = 0; n < 2000; n++) begin
            src_a = 8'($urandom); src_b = 8'($urandom); src_f = 8'($urandom);
            cyc(3'($urandom), ($urandom % 3) == 0, 8'($urandom));
        end

        // R9: reset again mid-run
        cur_req = "R9";
        rst = 1'b1; src_a = 8'h00; src_b = 8'h00; src_f = 8'h00;
        cyc(3'd0, 1'b0, 8'h00);
        rst = 1'b0;
        sweep();
        finish_run();
    end
endmodule